// File: doc/BRIEF.md
# Prescaled Edge-Aligned PWM Timer

This block is a small memory-mapped timer. One shared up-counter advances on ticks from a power-of-two prescaler and returns to zero after it reaches a programmable terminal value. Each of several output channels compares that counter against its own threshold and drives a PWM waveform. A channel can drive the waveform high-then-low or low-then-high, or hold its output low when it is not configured for edge-aligned PWM.

Software programs the block through a plain register port: a write strobe, an address and write data, plus a read data bus that is decoded combinationally from the address. While the counter runs, new terminal and threshold values are held in shadow registers. They move into the live compare logic only when the counter wraps, so a period is never cut short. While the counter is stopped, new values take effect on the next clock.

Top module: `pwm_timer`

## Requirements
- R1: After reset every register reads 0, the counter is 0 and every output is low.
- R2: The counter advances only while the run field (control register bits [4:3]) is 01. Codes 00, 10 and 11 hold the counter.
- R3: The prescale field k (control register bits [2:0]) makes the counter advance once every 2^k clocks. The first advance comes 2^k clocks after the write that starts the counter.
- R4: The counter runs 0, 1, ... up to the live terminal value and then returns to 0 on the next tick. After j clocks from start, its value is floor(j/2^k) mod (terminal+1).
- R5: Writes to the terminal register (0x18) and to a channel threshold register are shadowed while the counter runs. The live value changes only on the tick that wraps the counter. While the counter is stopped, the live value follows the shadow on the next clock.
- R6: A channel whose config bits [5:2] are 1010 (edge PWM, normal) drives its output high while counter < threshold and low otherwise.
- R7: A channel whose config bits [5:2] are 1001 (edge PWM, inverted) drives the complement of R6. Bits [3:2] = 11 also inverts.
- R8: A threshold of 0 holds the output at its inactive level. A threshold above the terminal value holds it at its active level.
- R9: A channel whose config bits [5:4] are not 10, or whose bits [3:2] are 00, drives its output low.
- R10: Register map: control at 0x10 (bits [5:0] read back; bit 5 is stored but does not change counting), counter at 0x14, terminal at 0x18, channel n config at 0x20+8n (bits [5:2] read back), channel n threshold at 0x24+8n. Unmapped addresses read 0.
- R11: Any write to the counter register clears the counter and the prescaler phase on that clock edge, whatever the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address for read and write |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, decoded combinationally from addr_i |
| pwm_o | output | NUM_CH | PWM outputs, one bit per channel |

## Verification
A bad prescaler phase or counter value shows at once in the counter read-back and in the PWM outputs. It shows within one prescaled tick of the fault, because every output is compared against the counter in the same clock. A live terminal or threshold value loaded at the wrong time shows up as a period of the wrong length, or as a duty change before the wrap. The bench sees it within one period by tracking the highest counter value in each period and the output level before and after the wrap.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int unsigned SC_OFS       = 'h10;
  localparam int unsigned CNT_OFS      = 'h14;
  localparam int unsigned MOD_OFS      = 'h18;
  localparam int unsigned CH_BASE      = 'h20;
  localparam int unsigned CH_STRIDE    = 8;
  localparam int unsigned CH_VAL_OFS   = 4;
  localparam logic [1:0]  RUN_INTERNAL = 2'b01;

  typedef struct packed {
    logic ms_b;
    logic ms_a;
    logic els_b;
    logic els_a;
  } ch_cfg_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned PRE_W = 3,
  localparam int unsigned DIV_W = (1 << PRE_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] sel_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    for (int b = 0; b < DIV_W; b++) mask[b] = (b < int'(sel_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (!run_i || clr_i) div_q <= '0;
    else                      div_q <= div_q + 1'b1;
  end

  assign tick_o = run_i && ((div_q & mask) == mask);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] mod_buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] mod_act_o,
  output logic             load_o
);
  logic [CNT_W-1:0] cnt_q, mod_q;
  logic             wrap;

  // >= so a live terminal below the current count still wraps
  assign wrap   = tick_i && !clr_i && (cnt_q >= mod_q);
  assign load_o = wrap || !run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (wrap)   cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mod_q <= '0;
    else if (load_o) mod_q <= mod_buf_i;
  end

  assign cnt_o     = cnt_q;
  assign mod_act_o = mod_q;
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel import pwm_timer_pkg::*; #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_buf_i,
  input  ch_cfg_t          cfg_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] val_act_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] val_q;
  logic             edge_mode, enabled, active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (load_i) val_q <= val_buf_i;
  end

  assign edge_mode = cfg_i.ms_b && !cfg_i.ms_a;
  assign enabled   = edge_mode && (cfg_i.els_b || cfg_i.els_a);
  assign active    = cnt_i < val_q;
  assign pwm_o     = enabled && (active ^ cfg_i.els_a);
  assign val_act_o = val_q;
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer import pwm_timer_pkg::*; #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRE_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  localparam int unsigned SC_W = PRE_W + 3;

  logic [PRE_W-1:0] presc_q;
  logic [1:0]       mode_q;
  logic             center_q;
  logic [CNT_W-1:0] mod_buf_q;
  ch_cfg_t          ch_cfg_q  [NUM_CH];
  logic [CNT_W-1:0] val_buf_q [NUM_CH];
  logic [CNT_W-1:0] val_act   [NUM_CH];

  logic             run, tick, cnt_clr, load;
  logic [CNT_W-1:0] cnt, mod_act;
  logic             wr_sc, wr_mod;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign wr_sc   = wr_en_i && (addr_i == ADDR_W'(SC_OFS));
  assign wr_mod  = wr_en_i && (addr_i == ADDR_W'(MOD_OFS));
  assign cnt_clr = wr_en_i && (addr_i == ADDR_W'(CNT_OFS));
  assign run     = (mode_q == RUN_INTERNAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q  <= '0;
      mode_q   <= '0;
      center_q <= 1'b0;
    end else if (wr_sc) begin
      presc_q  <= wdata_i[PRE_W-1:0];
      mode_q   <= wdata_i[PRE_W+1:PRE_W];
      center_q <= wdata_i[PRE_W+2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mod_buf_q <= '0;
    else if (wr_mod) mod_buf_q <= wdata_i[CNT_W-1:0];
  end

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (cnt_clr),
    .sel_i  (presc_q),
    .tick_o (tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .tick_i    (tick),
    .clr_i     (cnt_clr),
    .mod_buf_i (mod_buf_q),
    .cnt_o     (cnt),
    .mod_act_o (mod_act),
    .load_o    (load)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : gen_ch
    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CH_BASE + CH_STRIDE * i);
    localparam logic [ADDR_W-1:0] VAL_A = ADDR_W'(CH_BASE + CH_STRIDE * i + CH_VAL_OFS);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ch_cfg_q[i]  <= '0;
        val_buf_q[i] <= '0;
      end else if (wr_en_i) begin
        if (addr_i == CFG_A) ch_cfg_q[i]  <= wdata_i[5:2];
        if (addr_i == VAL_A) val_buf_q[i] <= wdata_i[CNT_W-1:0];
      end
    end

    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .val_buf_i (val_buf_q[i]),
      .cfg_i     (ch_cfg_q[i]),
      .cnt_i     (cnt),
      .val_act_o (val_act[i]),
      .pwm_o     (pwm_o[i])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(SC_OFS))  rdata_o = DATA_W'({center_q, mode_q, presc_q});
    if (addr_i == ADDR_W'(CNT_OFS)) rdata_o = DATA_W'(cnt);
    if (addr_i == ADDR_W'(MOD_OFS)) rdata_o = DATA_W'(mod_buf_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_i == ADDR_W'(CH_BASE + CH_STRIDE * i))
        rdata_o = DATA_W'({ch_cfg_q[i], 2'b00});
      if (addr_i == ADDR_W'(CH_BASE + CH_STRIDE * i + CH_VAL_OFS))
        rdata_o = DATA_W'(val_buf_q[i]);
    end
  end

  logic [SC_W-1:0] unused_sc_w;
  assign unused_sc_w = '0;
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk import pwm_timer_pkg::*; #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run,
  input logic             tick,
  input logic             clr,
  input logic             load,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] mod_act,
  input ch_cfg_t          cfg0,
  input logic [CNT_W-1:0] val0,
  input logic             pwm0
);
  assert_hold_when_stopped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !clr) |=> $stable(cnt));

  assert_no_step_between_ticks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !tick && !clr) |=> $stable(cnt));

  assert_wrap_to_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !clr && (cnt >= mod_act)) |=> (cnt == '0));

  assert_terminal_shadowed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(mod_act));

  assert_zero_threshold_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg0 == 4'b1010) && (val0 == '0)) |-> !pwm0);

  assert_clear_counter_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (cnt == '0));
endmodule

bind pwm_timer pwm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run     (run),
  .tick    (tick),
  .clr     (cnt_clr),
  .load    (load),
  .cnt     (cnt),
  .mod_act (mod_act),
  .cfg0    (ch_cfg_q[0]),
  .val0    (val_act[0]),
  .pwm0    (pwm_o[0])
);

// File: tb/sim_pwm_timer.sv
module sim_pwm_timer;
  localparam int NUM_CH = 2;
  localparam logic [7:0] A_SC  = 8'h10;
  localparam logic [7:0] A_CNT = 8'h14;
  localparam logic [7:0] A_MOD = 8'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NUM_CH-1:0] pwm;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_timer #(.NUM_CH(NUM_CH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  function automatic logic [7:0] cfg_a(int n); return 8'(32 + 8 * n); endfunction
  function automatic logic [7:0] val_a(int n); return 8'(36 + 8 * n); endfunction

  function automatic logic exp_out(int c, int v, logic [31:0] cfg);
    logic act;
    if (cfg[5:4] != 2'b10 || cfg[3:2] == 2'b00) return 1'b0;
    act = (c < v);
    return cfg[2] ? ~act : act;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cnt(int target);
    logic [31:0] c;
    for (int g = 0; g < 1000; g++) begin
      rd(A_CNT, c);
      if (c == 32'(target)) break;
      step(1);
    end
  endtask

  task automatic setup(int k, int m, int v0, logic [31:0] c0, int v1, logic [31:0] c1);
    wr(A_SC, 32'h0);
    wr(A_MOD, 32'(m));
    wr(cfg_a(0), c0); wr(val_a(0), 32'(v0));
    wr(cfg_a(1), c1); wr(val_a(1), 32'(v1));
    wr(A_CNT, 32'h0);
    wr(A_SC, 32'h8 | 32'(k));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r2;
    void'($urandom(32'd4242));
    step(2);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(A_SC, r);  check("R1 ctrl", r, 0);
    rd(A_CNT, r); check("R1 cnt", r, 0);
    rd(A_MOD, r); check("R1 mod", r, 0);
    for (int n = 0; n < NUM_CH; n++) begin
      rd(cfg_a(n), r); check("R1 cfg", r, 0);
      rd(val_a(n), r); check("R1 val", r, 0);
    end
    check("R1 pwm", pwm, 0);

    // R10 register map and read masks
    wr(A_SC, 32'hFF);      rd(A_SC, r);     check("R10 ctrl mask", r, 32'h3F);
    wr(cfg_a(1), 32'hFF);  rd(cfg_a(1), r); check("R10 cfg mask", r, 32'h3C);
    wr(val_a(1), 32'h1234); rd(val_a(1), r); check("R10 val", r, 32'h1234);
    rd(8'h08, r); check("R10 unmapped", r, 0);
    rd(8'h1C, r); check("R10 unmapped 1c", r, 0);
    rd(A_CNT, r); check("R2 mode 11 holds", r, 0);

    // R3 / R4 directed period checks
    begin
      int ks[3] = '{0, 2, 7};
      int ms[3] = '{4, 3, 1};
      for (int t = 0; t < 3; t++) begin
        setup(ks[t], ms[t], 0, 32'h0, 0, 32'h0);
        for (int j = 0; j < (2 * (ms[t] + 1)) << ks[t]; j++) begin
          rd(A_CNT, r);
          check("R3 R4 count", r, ((j >> ks[t]) % (ms[t] + 1)));
          step(1);
        end
      end
    end

    // R11 clear while running, R2 hold with other run codes
    setup(0, 100, 0, 32'h0, 0, 32'h0);
    step(10);
    wr(A_CNT, 32'h0); rd(A_CNT, r); check("R11 clear", r, 0);
    step(1);          rd(A_CNT, r); check("R11 resume", r, 1);
    step(5);
    wr(A_SC, 32'h10); rd(A_CNT, r);
    step(5);          rd(A_CNT, r2); check("R2 mode 10 holds", r2, r);
    wr(A_SC, 32'h00); step(4); rd(A_CNT, r); check("R2 mode 00 holds", r, r2);
    wr(A_SC, 32'h20); step(4); rd(A_CNT, r); check("R2 center bit alone holds", r, r2);

    // R5 shadowed terminal and threshold
    setup(0, 9, 5, 32'h28, 0, 32'h0);
    begin
      int max1 = 0, max2 = 0;
      bit wrapped = 0;
      wait_cnt(2);
      wr(A_MOD, 32'd3);
      for (int j = 0; j < 14; j++) begin
        rd(A_CNT, r);
        if (r == 0) wrapped = 1;
        if (!wrapped && int'(r) > max1) max1 = int'(r);
        if (wrapped && int'(r) > max2) max2 = int'(r);
        step(1);
      end
      check("R5 old terminal kept", max1, 9);
      check("R5 new terminal at wrap", max2, 3);
      wait_cnt(1);
      wr(val_a(0), 32'd1);
      wrapped = 0;
      for (int j = 0; j < 10; j++) begin
        rd(A_CNT, r);
        if (r == 0) wrapped = 1;
        check("R5 threshold shadow", pwm[0], wrapped ? exp_out(int'(r), 1, 32'h28) : 1'b1);
        step(1);
      end
    end

    // R8 threshold boundaries
    setup(0, 5, 0, 32'h28, 6, 32'h28);
    for (int j = 0; j < 12; j++) begin
      check("R8 zero threshold", pwm[0], 0);
      check("R8 above terminal", pwm[1], 1);
      step(1);
    end
    setup(0, 5, 0, 32'h24, 6, 32'h24);
    for (int j = 0; j < 12; j++) begin
      check("R8 zero threshold inverted", pwm[0], 1);
      check("R8 above terminal inverted", pwm[1], 0);
      step(1);
    end

    // R6 R7 R9 R4 random configurations
    for (int it = 0; it < 30; it++) begin
      int k, m, v[2];
      logic [31:0] c[2];
      k = int'($urandom % 3);
      m = 2 + int'($urandom % 30);
      for (int n = 0; n < 2; n++) begin
        v[n] = int'($urandom % (m + 3));
        case ($urandom % 6)
          0: c[n] = 32'h28;
          1: c[n] = 32'h24;
          2: c[n] = 32'h2C;
          3: c[n] = 32'h20;
          4: c[n] = 32'h18;
          default: c[n] = 32'h08;
        endcase
      end
      setup(k, m, v[0], c[0], v[1], c[1]);
      for (int j = 0; j < (2 * (m + 1)) << k; j++) begin
        rd(A_CNT, r);
        check("R4 random count", r, ((j >> k) % (m + 1)));
        check("R6 R7 R9 ch0", pwm[0], exp_out(int'(r), v[0], c[0]));
        check("R6 R7 R9 ch1", pwm[1], exp_out(int'(r), v[1], c[1]));
        step(1);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule